// File: doc/BRIEF.md
# Dual-Channel Disk Interrupt Gate

This block sits between the two drive channels of a disk interface card and the host. Each drive raises a level-sensitive interrupt line. The block synchronises that line and shows it in a per-channel status byte. It merges the enabled requests of both channels into one host interrupt. The host reaches it over a simple byte-wide register bus, which has an address, a read strobe, a write strobe and a window flag that picks either the base window or the extended window.

Each channel's interrupt enable is controlled by the type of bus access, not by the data written. A write of any value to the channel's control address turns the enable on. A read of that same address turns it off. A configuration byte in the base window does two things: it opens the extended window, and it steers the single DMA engine to one channel. Writing zero to it is the shutdown state. A fixed 4-bit board identity can be read one bit per byte from the base window, so software can tell which card variant it has found.

The bus has no flow control and a read always completes at once. For that reason there is no valid/ready pairing: every strobe is taken in the cycle it is asserted. Read data is registered and is valid from the clock edge that ends the read cycle until the next read.

Top module: `ide_irq_gate`

## Requirements
- R1: After reset `host_irq`, `ext_win_en` and `dma_sel` are 0, both channel enables are clear, and the configuration byte reads 0x00.
- R2: While the extended window is open, a write of any data value to extended offset 0x2200 (channel 0) or 0x3200 (channel 1) sets that channel's interrupt enable.
- R3: While the extended window is open, a read of a channel control offset (0x2200 or 0x3200) clears that channel's enable and returns 0x00.
- R4: Extended offsets 0x2290 (channel 0) and 0x3290 (channel 1) read with bit 0 equal to the synchronised drive line of that channel and bits 7:1 zero. Bit 0 returns to 0 once the drive drops its line.
- R5: `host_irq` is high exactly when some channel has both its synchronised request and its enable high. It follows that condition one clock later.
- R6: A write to base offset 0x0000 stores the whole byte, and a read returns it. Bit 5 drives `ext_win_en` and bit 0 drives `dma_sel` (0 routes the DMA engine to channel 0, 1 routes it to channel 1).
- R7: While `ext_win_en` is 0, every extended-window access reads 0x00 and leaves both enables unchanged.
- R8: Base offsets 0x2280, 0x2284, 0x2288 and 0x228C read bit 0 equal to identity bits 0, 1, 2 and 3, with bits 7:1 zero. The default identity is 3.
- R9: A read of any unmapped address returns 0x00 and changes no state.
- R10: When the read and write strobes are asserted in the same cycle, the access acts as a write only. It has no read side effect.
- R11: Writing 0x00 to the configuration byte closes the extended window and routes DMA to channel 0. The channel enables are not changed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_irq | input | 2 | Raw level interrupt line from each drive channel |
| bus_ext | input | 1 | 1 = access targets the extended window, 0 = base window |
| bus_addr | input | 14 | Byte offset within the selected window |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| host_irq | output | 1 | Combined, gated interrupt to the host |
| ext_win_en | output | 1 | Extended window enable (configuration bit 5) |
| dma_sel | output | 1 | DMA channel routing (configuration bit 0) |

## Verification
Random sequences set the drive lines to each of the four patterns (none, one channel, the other channel, both) together with every combination of the two enables. This separates an OR of the enabled requests from an AND, from a gate that ignores the enables, and from swapped channels. Control writes are made with random data, including 0x00, so a design that reads the data value instead of the access type is exposed. Directed cases try extended accesses with the window closed, simultaneous strobes, the shutdown write, identity bits and unmapped reads. In each of these the host interrupt shows whether a hidden enable moved.

// File: rtl/ide_gate_pkg.sv
package ide_gate_pkg;
  localparam int ADDR_W   = 14;
  localparam int N_CH     = 2;
  localparam int ID_BITS  = 4;

  localparam logic [ADDR_W-1:0] CFG_OFS   = 14'h0000;
  localparam logic [ADDR_W-1:0] ID_BASE   = 14'h2280;
  localparam logic [ADDR_W-1:0] CTRL_OFS0 = 14'h2200;
  localparam logic [ADDR_W-1:0] CTRL_OFS1 = 14'h3200;
  localparam logic [ADDR_W-1:0] STAT_OFS0 = 14'h2290;
  localparam logic [ADDR_W-1:0] STAT_OFS1 = 14'h3290;

  localparam int CFG_WIN_BIT = 5;
  localparam int CFG_DMA_BIT = 0;

  typedef enum logic [1:0] {
    RSEL_NONE = 2'd0,
    RSEL_CFG  = 2'd1,
    RSEL_ID   = 2'd2,
    RSEL_STAT = 2'd3
  } rsel_e;

  function automatic logic [ADDR_W-1:0] ctrl_ofs(input int ch);
    return (ch == 0) ? CTRL_OFS0 : CTRL_OFS1;
  endfunction

  function automatic logic [ADDR_W-1:0] stat_ofs(input int ch);
    return (ch == 0) ? STAT_OFS0 : STAT_OFS1;
  endfunction
endpackage

// File: rtl/gate_sync.sv
module gate_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] shreg;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = shreg[STAGES-1];
endmodule

// File: rtl/gate_decode.sv
module gate_decode
  import ide_gate_pkg::*;
(
  input  logic              bus_ext,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic              win_open,
  output logic              cfg_we,
  output logic [N_CH-1:0]   ctrl_set,
  output logic [N_CH-1:0]   ctrl_clr,
  output logic              rd_take,
  output rsel_e             rsel,
  output logic              stat_ch,
  output logic [1:0]        id_idx
);
  logic ext_ok;
  logic rd_only;
  logic hit_cfg;
  logic hit_id;
  logic [N_CH-1:0] hit_ctrl;
  logic [N_CH-1:0] hit_stat;

  assign ext_ok  = bus_ext && win_open;
  assign rd_only = bus_rd && !bus_wr;
  assign rd_take = rd_only;

  assign hit_cfg = !bus_ext && (bus_addr == CFG_OFS);
  assign hit_id  = !bus_ext && (bus_addr[ADDR_W-1:4] == ID_BASE[ADDR_W-1:4])
                   && (bus_addr[1:0] == 2'b00);
  assign id_idx  = bus_addr[3:2];

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
      assign hit_ctrl[c] = ext_ok && (bus_addr == ctrl_ofs(c));
      assign hit_stat[c] = ext_ok && (bus_addr == stat_ofs(c));
      assign ctrl_set[c] = hit_ctrl[c] && bus_wr;
      assign ctrl_clr[c] = hit_ctrl[c] && rd_only;
    end
  endgenerate

  assign cfg_we  = hit_cfg && bus_wr;
  assign stat_ch = hit_stat[1];

  always_comb begin
    if (hit_cfg)        rsel = RSEL_CFG;
    else if (hit_id)    rsel = RSEL_ID;
    else if (|hit_stat) rsel = RSEL_STAT;
    else                rsel = RSEL_NONE;
  end
endmodule

// File: rtl/gate_chan.sv
module gate_chan #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic drv_line,
  input  logic en_set,
  input  logic en_clr,
  output logic pend,
  output logic en,
  output logic active
);
  gate_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (drv_line),
    .q    (pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en <= 1'b0;
    else if (en_set) en <= 1'b1;
    else if (en_clr) en <= 1'b0;
  end

  assign active = pend && en;
endmodule

// File: rtl/ide_irq_gate.sv
module ide_irq_gate
  import ide_gate_pkg::*;
#(
  parameter int           SYNC_STAGES = 2,
  parameter logic [3:0]   BOARD_ID    = 4'd3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        drv_irq,
  input  logic              bus_ext,
  input  logic [13:0]       bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              host_irq,
  output logic              ext_win_en,
  output logic              dma_sel
);
  logic [7:0]      cfg_q;
  logic [7:0]      rdata_q;
  logic            irq_q;
  logic            cfg_we;
  logic [N_CH-1:0] ctrl_set;
  logic [N_CH-1:0] ctrl_clr;
  logic            rd_take;
  rsel_e           rsel;
  logic            stat_ch;
  logic [1:0]      id_idx;
  logic [N_CH-1:0] chan_pend;
  logic [N_CH-1:0] chan_en;
  logic [N_CH-1:0] chan_act;
  logic [7:0]      rd_next;

  gate_decode u_dec (
    .bus_ext (bus_ext),
    .bus_addr(bus_addr),
    .bus_rd  (bus_rd),
    .bus_wr  (bus_wr),
    .win_open(cfg_q[CFG_WIN_BIT]),
    .cfg_we  (cfg_we),
    .ctrl_set(ctrl_set),
    .ctrl_clr(ctrl_clr),
    .rd_take (rd_take),
    .rsel    (rsel),
    .stat_ch (stat_ch),
    .id_idx  (id_idx)
  );

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_chan
      gate_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
        .clk     (clk),
        .rst_n   (rst_n),
        .drv_line(drv_irq[c]),
        .en_set  (ctrl_set[c]),
        .en_clr  (ctrl_clr[c]),
        .pend    (chan_pend[c]),
        .en      (chan_en[c]),
        .active  (chan_act[c])
      );
    end
  endgenerate

  always_comb begin
    rd_next = 8'h00;
    case (rsel)
      RSEL_CFG:  rd_next = cfg_q;
      RSEL_ID:   rd_next = {7'b0, BOARD_ID[id_idx]};
      RSEL_STAT: rd_next = {7'b0, chan_pend[stat_ch]};
      default:   rd_next = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= 8'h00;
      rdata_q <= 8'h00;
      irq_q   <= 1'b0;
    end else begin
      if (cfg_we)  cfg_q   <= bus_wdata;
      if (rd_take) rdata_q <= rd_next;
      irq_q <= |chan_act;
    end
  end

  assign bus_rdata  = rdata_q;
  assign host_irq   = irq_q;
  assign ext_win_en = cfg_q[CFG_WIN_BIT];
  assign dma_sel    = cfg_q[CFG_DMA_BIT];
endmodule

// File: rtl/ide_irq_gate_chk.sv
module ide_irq_gate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_ext,
  input logic [13:0] bus_addr,
  input logic        bus_rd,
  input logic        bus_wr,
  input logic [7:0]  bus_wdata,
  input logic [7:0]  bus_rdata,
  input logic        host_irq,
  input logic        ext_win_en,
  input logic        dma_sel,
  input logic [1:0]  en,
  input logic [1:0]  pend
);
  // R2: a write to the channel 0 control offset leaves the enable set
  p_wr_sets_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_ext && ext_win_en && bus_addr == 14'h2200) |=> en[0]);

  // R3: a lone read of the channel 1 control offset clears the enable and returns zero
  p_rd_clears_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_ext && ext_win_en && bus_addr == 14'h3200)
      |=> (!en[1] && bus_rdata == 8'h00));

  // R5: the host interrupt only follows an enabled pending request
  p_irq_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_irq) |-> $past(|(en & pend)));

  // R6: a configuration write lands on the routing outputs
  p_cfg_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_ext && bus_addr == 14'h0000)
      |=> (dma_sel == $past(bus_wdata[0]) && ext_win_en == $past(bus_wdata[5])));

  // R7: with the window closed the enables cannot move
  p_closed_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_win_en |=> $stable(en));

  // R10: simultaneous strobes on a control offset never clear the enable
  p_rdwr_is_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_wr && bus_ext && ext_win_en && bus_addr == 14'h2200) |=> en[0]);

  // R9: reading an offset that nothing decodes returns zero
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && !bus_ext && bus_addr == 14'h1234) |=> bus_rdata == 8'h00);
endmodule

bind ide_irq_gate ide_irq_gate_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_ext   (bus_ext),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .host_irq  (host_irq),
  .ext_win_en(ext_win_en),
  .dma_sel   (dma_sel),
  .en        (chan_en),
  .pend      (chan_pend)
);

// File: tb/ide_irq_gate_tb.sv
module ide_irq_gate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  drv_irq = 2'b00;
  logic        bus_ext = 1'b0;
  logic [13:0] bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        host_irq;
  logic        ext_win_en;
  logic        dma_sel;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [1:0] m_en = 2'b00;
  logic [7:0] m_cfg = 8'h00;
  localparam logic [3:0] ID = 4'd3;

  always #5 clk = ~clk;

  ide_irq_gate u_dut (
    .clk(clk), .rst_n(rst_n), .drv_irq(drv_irq), .bus_ext(bus_ext),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .host_irq(host_irq),
    .ext_win_en(ext_win_en), .dma_sel(dma_sel)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic ext, input logic [13:0] a);
    if (!ext) begin
      if (a == 14'h0000) return m_cfg;
      if (a[13:4] == 10'h228 && a[1:0] == 2'b00) return {7'b0, ID[a[3:2]]};
      return 8'h00;
    end
    if (!m_cfg[5]) return 8'h00;
    if (a == 14'h2290) return {7'b0, drv_irq[0]};
    if (a == 14'h3290) return {7'b0, drv_irq[1]};
    return 8'h00;
  endfunction

  function automatic int ctrl_ch(input logic ext, input logic [13:0] a);
    if (!ext || !m_cfg[5]) return -1;
    if (a == 14'h2200) return 0;
    if (a == 14'h3200) return 1;
    return -1;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic ext, input logic [13:0] a, input logic [7:0] d);
    int ch;
    @(negedge clk);
    bus_ext = ext; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    ch = ctrl_ch(ext, a);
    if (ch >= 0) m_en[ch] = 1'b1;
    if (!ext && a == 14'h0000) m_cfg = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic ext, input logic [13:0] a, output logic [7:0] d,
                          output logic [7:0] e);
    int ch;
    @(negedge clk);
    bus_ext = ext; bus_addr = a; bus_rd = 1'b1;
    e = exp_read(ext, a);
    ch = ctrl_ch(ext, a);
    if (ch >= 0) m_en[ch] = 1'b0;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic bus_rdwr(input logic ext, input logic [13:0] a, input logic [7:0] d);
    int ch;
    @(negedge clk);
    bus_ext = ext; bus_addr = a; bus_wdata = d; bus_rd = 1'b1; bus_wr = 1'b1;
    ch = ctrl_ch(ext, a);
    if (ch >= 0) m_en[ch] = 1'b1;
    if (!ext && a == 14'h0000) m_cfg = d;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  function automatic logic exp_irq();
    return |(drv_irq & m_en);
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd, ex;
    void'($urandom(32'h5eed_0042));
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    check("R1 host_irq", {7'b0, host_irq}, 8'h00);
    check("R1 ext_win_en", {7'b0, ext_win_en}, 8'h00);
    check("R1 dma_sel", {7'b0, dma_sel}, 8'h00);
    bus_read(1'b0, 14'h0000, rd, ex);
    check("R1 cfg reads zero", rd, 8'h00);

    // R8 identity bits
    for (int k = 0; k < 4; k++) begin
      bus_read(1'b0, 14'h2280 + 14'(4 * k), rd, ex);
      check("R8 identity bit", rd, {7'b0, ID[k]});
    end

    // R7 window closed: control write ignored, status reads zero
    drv_irq = 2'b11;
    bus_write(1'b1, 14'h2200, 8'hff);
    idle(4);
    bus_read(1'b1, 14'h2290, rd, ex);
    check("R7 closed status read", rd, 8'h00);
    bus_write(1'b0, 14'h0000, 8'h20);
    idle(4);
    check("R7 enable unchanged by closed write", {7'b0, host_irq}, 8'h00);

    // R6 config readback and routing
    bus_write(1'b0, 14'h0000, 8'h21);
    bus_read(1'b0, 14'h0000, rd, ex);
    check("R6 cfg readback", rd, 8'h21);
    check("R6 dma_sel", {7'b0, dma_sel}, 8'h01);
    check("R6 ext_win_en", {7'b0, ext_win_en}, 8'h01);

    // R4 status bits
    bus_read(1'b1, 14'h2290, rd, ex);
    check("R4 status ch0", rd, 8'h01);
    drv_irq = 2'b01;
    idle(4);
    bus_read(1'b1, 14'h3290, rd, ex);
    check("R4 status ch1 cleared", rd, 8'h00);

    // R2 write with zero data enables
    bus_write(1'b1, 14'h2200, 8'h00);
    idle(2);
    check("R2 zero-data write enables", {7'b0, host_irq}, 8'h01);

    // R3 read disables and returns zero
    bus_read(1'b1, 14'h2200, rd, ex);
    check("R3 ctrl read data", rd, 8'h00);
    idle(2);
    check("R3 read disables", {7'b0, host_irq}, 8'h00);

    // R10 simultaneous strobes act as write
    bus_rdwr(1'b1, 14'h2200, 8'h5a);
    idle(2);
    check("R10 rd+wr enables", {7'b0, host_irq}, 8'h01);

    // R9 unmapped reads
    bus_read(1'b0, 14'h1234, rd, ex);
    check("R9 base unmapped", rd, 8'h00);
    bus_read(1'b1, 14'h2204, rd, ex);
    check("R9 ext unmapped", rd, 8'h00);
    idle(2);
    check("R9 no side effect", {7'b0, host_irq}, 8'h01);

    // R11 shutdown write
    bus_write(1'b0, 14'h0000, 8'h00);
    idle(2);
    check("R11 window closed", {7'b0, ext_win_en}, 8'h00);
    check("R11 dma to ch0", {7'b0, dma_sel}, 8'h00);
    check("R11 enables kept", {7'b0, host_irq}, 8'h01);
    bus_write(1'b0, 14'h0000, 8'h20);

    // R5 random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      logic ext;
      logic [13:0] a;
      drv_irq = 2'($urandom_range(0, 3));
      idle(4);
      op = $urandom_range(0, 9);
      ext = (op < 8);
      case ($urandom_range(0, 5))
        0: a = 14'h2200;
        1: a = 14'h3200;
        2: a = 14'h2290;
        3: a = 14'h3290;
        4: a = 14'h0000;
        default: a = 14'($urandom);
      endcase
      if (!ext && a == 14'h0000) begin
        bus_write(1'b0, a, 8'h20 | 8'($urandom_range(0, 1)));
      end else if (op % 2 == 0) begin
        bus_write(ext, a, 8'($urandom));
      end else begin
        bus_read(ext, a, rd, ex);
        check("R4 R9 random read", rd, ex);
      end
      idle(2);
      check("R5 combined irq", {7'b0, host_irq}, {7'b0, exp_irq()});
      check("R6 dma_sel follows cfg", {7'b0, dma_sel}, {7'b0, m_cfg[0]});
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule